// File: doc/BRIEF.md
# Serial Code Entry Comparator

The block takes a five-bit code that an operator keys in one bit at a time. A level input sets the value of the next bit and a trigger input commits it. When the fifth bit arrives, the block compares the whole entry with a code that is fixed by a parameter. It then shows the result on a bank of seven multiplexed seven-segment digits.

Nothing is shown while the entry is incomplete. Once the fifth bit lands, the five entered bits appear on digits 1 to 5 as the glyphs 0 and 1. Digit 6 shows E when the entry matches the stored code and n when it does not. Digit 7 stays dark. The picture holds for a fixed number of clock cycles, then every digit goes blank and the block accepts a fresh entry.

A single slow clock of about 1 kHz runs everything. Each cycle the block moves the active anode to the next digit. The trigger and the bit input each pass through a two-flop synchronizer, so that one press records exactly one bit.

Top module: `serial_code_cmp`

## Requirements
- R1: While `rst` is high and after it falls, every segment output is off (`seg_n` = 1111111), digit 1 holds the active scan slot, and any partial entry is discarded.
- R2: Each low-to-high transition of `trig_in` records exactly one bit, taken from `bit_in`, however long the trigger stays high.
- R3: While fewer than five bits have been entered, all segments stay off on every digit.
- R4: After the fifth bit, digit d1..d5 shows the i-th entered bit, with the first entered bit on d1. The glyphs are active-low, ordered a..g from `seg_n[6]` to `seg_n[0]`: 0 is 0000001 and 1 is 1001111.
- R5: While the result is shown, digit d6 shows E (0110000) if the first through fifth entered bits equal `CODE[4]` down to `CODE[0]`, and n (1101010) otherwise. The default `CODE` is 5'b11001.
- R6: The result stays lit for exactly `HOLD_CYCLES` clock cycles. After that every digit is blank and a new five-bit entry starts from empty.
- R7: Trigger presses made while the result is shown record nothing and change neither the shown bits, the verdict nor the hold length.
- R8: `an_n` is active-low with exactly one bit low per cycle. Bit i drives digit d(i+1), and the low bit advances one position per clock from d1 to d7 and wraps. Digit d7 is always blank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | About 1 kHz clock, also the scan rate |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Level giving the value of the next bit |
| trig_in | input | 1 | Press that commits the current bit value |
| an_n | output | 7 | Active-low digit enables, bit 0 is d1 |
| seg_n | output | 7 | Active-low segments, bit 6 is a, bit 0 is g |

## Verification
A bit dropped or recorded twice shifts the entry. The wrong glyph pattern then shows up on d1..d5 on the first scan pass after what should have been the fifth press, and d6 shows the wrong verdict within six cycles. A hold counter that is off by one makes the digits go dark one cycle early or late, or show the result after the model has blanked. A verdict register or shift register that a press during the hold can disturb changes the glyphs in the middle of the hold. Because the bench compares every cycle, each of these appears at the ports within one scan rotation of seven cycles.

// File: rtl/serial_code_cmp.sv
module serial_code_cmp #(
  parameter int          CODE_LEN    = 5,
  parameter logic [4:0]  CODE        = 5'b11001,
  parameter int          NUM_DIGITS  = 7,
  parameter int          HOLD_CYCLES = 5000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bit_in,
  input  logic                  trig_in,
  output logic [NUM_DIGITS-1:0] an_n,
  output logic [6:0]            seg_n
);
  localparam int CNT_W  = $clog2(CODE_LEN + 1);
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);
  localparam int SCAN_W = $clog2(NUM_DIGITS);

  localparam logic [6:0] GLY_0     = 7'b0000001;
  localparam logic [6:0] GLY_1     = 7'b1001111;
  localparam logic [6:0] GLY_E     = 7'b0110000;
  localparam logic [6:0] GLY_N     = 7'b1101010;
  localparam logic [6:0] GLY_BLANK = 7'b1111111;

  logic                trig_s1, trig_s2, trig_d, bit_s1, bit_s2;
  logic                press;
  logic [CODE_LEN-1:0] entry;
  logic [CNT_W-1:0]    count;
  logic                showing, matched;
  logic [HOLD_W-1:0]   hold;
  logic [SCAN_W-1:0]   scan;
  logic                sel_bit;

  assign press = trig_s2 & ~trig_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      {trig_s1, trig_s2, trig_d, bit_s1, bit_s2} <= '0;
    end else begin
      trig_s1 <= trig_in;
      trig_s2 <= trig_s1;
      trig_d  <= trig_s2;
      bit_s1  <= bit_in;
      bit_s2  <= bit_s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      entry   <= '0;
      count   <= '0;
      showing <= 1'b0;
      matched <= 1'b0;
      hold    <= '0;
    end else if (showing) begin
      if (hold == HOLD_W'(HOLD_CYCLES - 1)) begin
        showing <= 1'b0;
        entry   <= '0;
        count   <= '0;
        hold    <= '0;
      end else begin
        hold <= hold + 1'b1;
      end
    end else if (press) begin
      entry <= {entry[CODE_LEN-2:0], bit_s2};
      if (count == CNT_W'(CODE_LEN - 1)) begin
        showing <= 1'b1;
        matched <= ({entry[CODE_LEN-2:0], bit_s2} == CODE);
        hold    <= '0;
        count   <= '0;
      end else begin
        count <= count + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || scan == SCAN_W'(NUM_DIGITS - 1)) scan <= '0;
    else scan <= scan + 1'b1;
  end

  always_comb begin
    sel_bit = 1'b0;
    for (int i = 0; i < CODE_LEN; i++)
      if (scan == SCAN_W'(i)) sel_bit = entry[CODE_LEN-1-i];
  end

  assign an_n = ~(NUM_DIGITS'(1) << scan);

  always_comb begin
    if (!showing)                           seg_n = GLY_BLANK;
    else if (scan < SCAN_W'(CODE_LEN))      seg_n = sel_bit ? GLY_1 : GLY_0;
    else if (scan == SCAN_W'(CODE_LEN))     seg_n = matched ? GLY_E : GLY_N;
    else                                    seg_n = GLY_BLANK;
  end

  assert_one_anode_R8: assert property (@(posedge clk) disable iff (rst)
    $countones(~an_n) == 1);

  assert_scan_step_R8: assert property (@(posedge clk) disable iff (rst)
    (scan != SCAN_W'(NUM_DIGITS - 1)) |=> (scan == $past(scan) + 1'b1));

  assert_blank_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !showing |-> seg_n == GLY_BLANK);

  assert_fifth_press_R2: assert property (@(posedge clk) disable iff (rst)
    (!showing && press && count == CNT_W'(CODE_LEN - 1)) |=> showing);

  assert_hold_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (showing && hold != HOLD_W'(HOLD_CYCLES - 1)) |=> (showing && $stable(entry) && $stable(matched)));

  assert_hold_end_R6: assert property (@(posedge clk) disable iff (rst)
    (showing && hold == HOLD_W'(HOLD_CYCLES - 1)) |=> (!showing && count == '0));
endmodule

// File: tb/sim_serial_code_cmp.sv
module sim_serial_code_cmp;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_LEN = 5;
  localparam logic [4:0] CODE = 5'b11001;
  localparam int NUM_DIG = 7;
  localparam int HOLD = 40;

  localparam logic [6:0] G0 = 7'b0000001, G1 = 7'b1001111, GE = 7'b0110000,
                         GN = 7'b1101010, GB = 7'b1111111;

  logic clk = 0, rst = 1, bit_in = 0, trig_in = 0;
  logic [NUM_DIG-1:0] an_n;
  logic [6:0] seg_n;

  int tests = 0, fails = 0;
  string scen = "";

  serial_code_cmp #(.CODE_LEN(CODE_LEN), .CODE(CODE), .NUM_DIGITS(NUM_DIG), .HOLD_CYCLES(HOLD)) u0 (
    .clk(clk), .rst(rst), .bit_in(bit_in), .trig_in(trig_in), .an_n(an_n), .seg_n(seg_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  bit m_s1, m_s2, m_d, m_b1, m_b2, m_show, m_match, m_prev_show, m_rst;
  int slot, rem;
  bit q[$];
  bit shown[$];
  bit press_in_hold;

  always @(posedge clk) begin
    bit rise, bv;
    rise = m_s2 && !m_d;
    bv = m_b2;
    m_prev_show = m_show;
    m_rst = rst;
    if (rst) begin
      {m_s1, m_s2, m_d, m_b1, m_b2, m_show, m_match} = '0;
      slot = 0; rem = 0; q.delete(); press_in_hold = 0;
    end else begin
      m_d = m_s2; m_s2 = m_s1; m_s1 = trig_in; m_b2 = m_b1; m_b1 = bit_in;
      slot = (slot + 1) % NUM_DIG;
      if (m_show) begin
        if (rise) press_in_hold = 1;
        rem--;
        if (rem == 0) begin m_show = 0; q.delete(); press_in_hold = 0; end
      end else if (rise) begin
        q.push_back(bv);
        if (q.size() == CODE_LEN) begin
          m_show = 1; rem = HOLD; m_match = 1; shown = q;
          for (int i = 0; i < CODE_LEN; i++)
            if (q[i] != CODE[CODE_LEN-1-i]) m_match = 0;
        end
      end
    end
  end

  task automatic chk(string tag, logic [6:0] act, logic [6:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s%s t=%0t actual=%b expected=%b", tag, scen, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [6:0] e_seg, e_an;
    string tag;
    e_an = ~(7'(1) << slot);
    if (!m_show) e_seg = GB;
    else if (slot < CODE_LEN) e_seg = shown[slot] ? G1 : G0;
    else if (slot == CODE_LEN) e_seg = m_match ? GE : GN;
    else e_seg = GB;
    if (m_rst) tag = "R1";
    else if (m_show && (rem == 1 || rem == HOLD)) tag = "R6";
    else if (!m_show && m_prev_show) tag = "R6";
    else if (m_show && press_in_hold) tag = "R7";
    else if (!m_show) tag = "R3";
    else if (slot < CODE_LEN) tag = "R4";
    else if (slot == CODE_LEN) tag = "R5";
    else tag = "R8";
    chk("R8 anode ", an_n, e_an);
    chk({tag, " seg "}, seg_n, e_seg);
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(bit v, int high = 2, int low = 3);
    bit_in = v; tick(1);
    trig_in = 1; tick(high);
    trig_in = 0; tick(low);
  endtask

  task automatic enter(logic [4:0] c);
    for (int i = CODE_LEN - 1; i >= 0; i--) press(c[i]);
  endtask

  initial begin
    tick(4);
    chk("R1 reset seg ", seg_n, GB);
    rst = 0;
    scen = " match";      enter(5'b11001); tick(HOLD + 5);
    scen = " mismatch";   enter(5'b10011); tick(HOLD + 5);
    scen = " zeros";      enter(5'b00000); tick(HOLD + 5);
    scen = " R2 held";    press(1, 20, 3); press(1); press(0, 15, 2); press(0); press(1, 30, 2); tick(HOLD + 5);
    scen = " R7 hold";    enter(5'b11001); press(0); press(1); press(0); tick(HOLD);
    scen = " R7 after";   enter(5'b01110); tick(HOLD + 5);
    scen = " R1 mid";     press(1); press(1); rst = 1; tick(3); rst = 0;
    enter(5'b11001); tick(HOLD + 5);
    scen = " ones";       enter(5'b11111); tick(HOLD + 10);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule